// File: doc/BRIEF.md
# GPIO Bank Pin Controller

This block runs one bank of up to 32 general-purpose pins from a small word-addressed register port. Every pin has its own control word that sets the pin direction, the output buffer style, where the output value comes from, which peripheral function owns the pin, how the pad input raises interrupts, and the static pad settings (pull, drive strength, slew). One bank-wide register supplies the output value for pins placed in grouped-output mode. A read-only bank-wide word returns every synchronised pad level at once.

Pad inputs pass through a two-flop synchroniser. Per-pin detectors then watch them for a level or an edge, selected by a sparse four-bit mode code. A detected condition sets a per-pin status bit, and a single interrupt line is the OR of all of them. When a pin is handed to an alternate function, one of seven peripheral signals drives it instead of the register value, and that signal can optionally be inverted.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After a synchronous reset:
  - every pin control word reads 0x00000040 (interrupt mode 4, all other fields zero);
  - the grouped-output register, every pad configuration word and the interrupt status read 0;
  - `pad_oe` and `irq` are 0.
- R2: The register map uses word addresses:
  - 0..31: pin control words. Bits [16:0] are writable and bit 24 reads the pin's synchronised input level. All other bits read 0.
  - 32: read-only input level word. Writes to it are ignored.
  - 33: grouped-output register.
  - 34: interrupt status.
  - 64..95: pad configuration words.
  - Any other address reads 0.
  - A write takes effect at the clock edge on which `bus_wr` is high. Reads return data combinationally for `bus_addr`.
- R3: With function select [14:12] = 0, the pin output source depends on grouped-output bit [10]:
  - bit [10] = 0: the pin drives control bit [16];
  - bit [10] = 1: the pin drives its bit of the grouped-output register, and bit [16] has no effect.
- R4: Pin direction and output buffer:
  - Direction bit [9] = 0 keeps `pad_oe` low.
  - Buffer-type bit [8] = 0 (push-pull): with direction 1, `pad_oe` is 1 and `pad_out` equals the source.
  - Buffer-type bit [8] = 1 (open-drain): `pad_out` is 0, and `pad_oe` is 1 only while the source is low.
  - `pad_out` is 0 whenever `pad_oe` is 0.
- R5: Function select values 1..7 drive the pin from `alt_fn[i*7 + sel-1]`. Alternate-polarity bit [11] = 1 inverts that signal.
- R6: Power-gating field [3:2] = 2 forces `pad_oe` low and the pin's input level to 0. Value 3 behaves like value 0.
- R7: The input level appears at word 32 and control bit 24 two clock edges after `pad_in` changes. Input-disable bit [15] = 1 forces the level to 0.
- R8: Edge interrupt modes in field [7:4]:
  - 13 = rising, 14 = falling, 15 = both.
  - Each detected edge sets a sticky status bit (word 34) three edges after the pad change.
  - Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.
  - Mode 4 and every unlisted code never set status.
  - A disabled or gated input never sets status.
- R9: Level interrupt modes:
  - Mode 0 (low) and mode 1 (high) set status every cycle the enabled level holds, so a clear has no effect until the level goes away.
  - `irq` is high exactly when any status bit is set.
- R10: Static pad settings:
  - `pad_pull[2i+1:2i]` follows control bits [1:0].
  - Pad configuration word bit 0 drives `pad_slew[i]`, and bits [5:4] drive `pad_drive[2i+1:2i]`. The other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| pad_pull | output | 64 | Pull select, two bits per pin |
| pad_slew | output | 32 | Slew select per pin |
| pad_drive | output | 64 | Drive strength, two bits per pin |
| alt_fn | input | 224 | Alternate-function signals, seven per pin |
| irq | output | 1 | Bank interrupt |

## Verification
The checker watches per-cycle invariants on every clock:
- an open-drain pin never drives high;
- an input-direction or gated pin never enables its driver;
- a status bit never drops without a clear write;
- a disabled input never raises new status;
- a falling interrupt line is always preceded by a write to the status word.

Only the bench scenarios can show the following:
- the two-edge and three-edge latencies of the input path;
- that grouped-output mode really ignores control bit 16;
- the alternate-function routing and polarity;
- that level modes resist clearing while the level holds.

The bench shows these by comparing against an independent cycle model.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Word map of the register port
    localparam int ADDR_PIN_IN   = 32;
    localparam int ADDR_GRP_OUT  = 33;
    localparam int ADDR_INT_STAT = 34;
    localparam int ADDR_CFG_BASE = 64;

    // Per-pin control word (bit positions are software visible)
    typedef struct packed {
        logic [6:0] rsv_hi;     // [31:25]
        logic       pad_lvl;    // [24] read-only input level
        logic [6:0] rsv_mid;    // [23:17]
        logic       out_val;    // [16]
        logic       in_off;     // [15]
        logic [2:0] fsel;       // [14:12]
        logic       alt_inv;    // [11]
        logic       grp_out;    // [10]
        logic       dir_out;    // [9]
        logic       od;         // [8]
        logic [3:0] int_mode;   // [7:4]
        logic [1:0] pwr_sel;    // [3:2]
        logic [1:0] pull;       // [1:0]
    } pin_ctrl_t;

    typedef struct packed {
        logic [1:0] drive;
        logic       slew;
    } pad_cfg_t;

    localparam logic [31:0] CTRL_WR_MASK = 32'h0001_FFFF;
    localparam logic [31:0] CTRL_RST_VAL = 32'h0000_0040;
    localparam logic [1:0]  PWR_OFF      = 2'd2;

    typedef enum logic [3:0] {
        IM_LVL_LO = 4'd0,
        IM_LVL_HI = 4'd1,
        IM_OFF    = 4'd4,
        IM_RISE   = 4'd13,
        IM_FALL   = 4'd14,
        IM_BOTH   = 4'd15
    } int_mode_e;

    typedef struct packed {
        logic lo;
        logic hi;
        logic rise;
        logic fall;
    } det_sel_t;

    function automatic det_sel_t decode_mode(input logic [3:0] code);
        det_sel_t d;
        d = '0;
        case (code)
            IM_LVL_LO: d.lo   = 1'b1;
            IM_LVL_HI: d.hi   = 1'b1;
            IM_RISE:   d.rise = 1'b1;
            IM_FALL:   d.fall = 1'b1;
            IM_BOTH: begin
                d.rise = 1'b1;
                d.fall = 1'b1;
            end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_bank_pkg::*;
#(
    parameter int NALT = 7
) (
    input  logic [2:0]      fsel,
    input  logic            alt_inv,
    input  logic            grp_out,
    input  logic            out_val,
    input  logic            dir_out,
    input  logic            od,
    input  logic            gated,
    input  logic            grp_bit,
    input  logic [NALT-1:0] alt,
    output logic            pad_o,
    output logic            pad_oe
);

    logic       src;
    logic       drive;
    logic [2:0] alt_idx;

    assign alt_idx = fsel - 3'd1;
    assign drive   = dir_out && !gated;

    always_comb begin
        if (fsel == 3'd0) begin
            src = grp_out ? grp_bit : out_val;
        end else if (int'(fsel) <= NALT) begin
            src = alt[alt_idx] ^ alt_inv;
        end else begin
            src = 1'b0;
        end
    end

    always_comb begin
        if (od) begin
            pad_o  = 1'b0;
            pad_oe = drive && !src;
        end else begin
            pad_o  = drive && src;
            pad_oe = drive;
        end
    end

endmodule

// File: rtl/gpio_input_path.sv
module gpio_input_path
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NPINS-1:0]   pad_in,
    input  logic [NPINS-1:0]   enable,
    input  logic [NPINS*4-1:0] mode,
    input  logic [NPINS-1:0]   clear,
    output logic [NPINS-1:0]   level,
    output logic [NPINS-1:0]   status
);

    logic [NPINS-1:0] sync1, sync2, sync3;
    logic [NPINS-1:0] event_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= '0;
            sync2 <= '0;
            sync3 <= '0;
        end else begin
            sync1 <= pad_in;
            sync2 <= sync1;
            sync3 <= sync2;
        end
    end

    assign level = sync2 & enable;

    for (genvar i = 0; i < NPINS; i++) begin : g_det
        det_sel_t sel;
        assign sel = decode_mode(mode[i*4 +: 4]);
        assign event_hit[i] = enable[i] &&
            ((sel.lo   && !sync2[i]) ||
             (sel.hi   &&  sync2[i]) ||
             (sel.rise &&  sync2[i] && !sync3[i]) ||
             (sel.fall && !sync2[i] &&  sync3[i]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else begin
            status <= (status & ~clear) | event_hit;
        end
    end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int NALT   = 7,
    parameter int ADDR_W = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NPINS-1:0]      pad_in,
    output logic [NPINS-1:0]      pad_out,
    output logic [NPINS-1:0]      pad_oe,
    output logic [NPINS*2-1:0]    pad_pull,
    output logic [NPINS-1:0]      pad_slew,
    output logic [NPINS*2-1:0]    pad_drive,
    input  logic [NPINS*NALT-1:0] alt_fn,
    output logic                  irq
);

    localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1;

    pin_ctrl_t             ctrl_q [NPINS];
    pad_cfg_t              cfg_q  [NPINS];
    logic [NPINS-1:0]      grp_q;
    logic [NPINS*32-1:0]   ctrl_flat;
    logic [NPINS*4-1:0]    mode_flat;
    logic [NPINS-1:0]      in_en;
    logic [NPINS-1:0]      in_lvl;
    logic [NPINS-1:0]      int_stat;
    logic [NPINS-1:0]      stat_clr;
    logic [PIN_W-1:0]      idx;
    logic                  ctrl_hit;
    logic                  cfg_hit;
    pin_ctrl_t             rd_ctrl;

    assign idx      = bus_addr[PIN_W-1:0];
    assign ctrl_hit = int'(bus_addr) < NPINS;
    assign cfg_hit  = (int'(bus_addr) >= ADDR_CFG_BASE) &&
                      (int'(bus_addr) < ADDR_CFG_BASE + NPINS);

    // Register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPINS; i++) begin
                ctrl_q[i] <= pin_ctrl_t'(CTRL_RST_VAL);
                cfg_q[i]  <= '0;
            end
            grp_q <= '0;
        end else if (bus_wr) begin
            if (ctrl_hit) begin
                ctrl_q[idx] <= pin_ctrl_t'(bus_wdata & CTRL_WR_MASK);
            end
            if (cfg_hit) begin
                cfg_q[idx] <= '{drive: bus_wdata[5:4], slew: bus_wdata[0]};
            end
            if (bus_addr == ADDR_W'(ADDR_GRP_OUT)) begin
                grp_q <= bus_wdata[NPINS-1:0];
            end
        end
    end

    assign stat_clr = (bus_wr && bus_addr == ADDR_W'(ADDR_INT_STAT)) ?
                      bus_wdata[NPINS-1:0] : '0;

    // Read mux
    always_comb begin
        bus_rdata = '0;
        rd_ctrl   = ctrl_q[idx];
        rd_ctrl.pad_lvl = in_lvl[idx];
        if (ctrl_hit) begin
            bus_rdata = rd_ctrl;
        end else if (cfg_hit) begin
            bus_rdata = {26'b0, cfg_q[idx].drive, 3'b0, cfg_q[idx].slew};
        end else if (bus_addr == ADDR_W'(ADDR_PIN_IN)) begin
            bus_rdata[NPINS-1:0] = in_lvl;
        end else if (bus_addr == ADDR_W'(ADDR_GRP_OUT)) begin
            bus_rdata[NPINS-1:0] = grp_q;
        end else if (bus_addr == ADDR_W'(ADDR_INT_STAT)) begin
            bus_rdata[NPINS-1:0] = int_stat;
        end
    end

    // Per-pin output path and static pad settings
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic gated;
        assign gated = ctrl_q[i].pwr_sel == PWR_OFF;
        assign in_en[i] = !ctrl_q[i].in_off && !gated;
        assign mode_flat[i*4 +: 4]  = ctrl_q[i].int_mode;
        assign ctrl_flat[i*32 +: 32] = ctrl_q[i];
        assign pad_pull[i*2 +: 2]   = ctrl_q[i].pull;
        assign pad_slew[i]          = cfg_q[i].slew;
        assign pad_drive[i*2 +: 2]  = cfg_q[i].drive;

        gpio_pad_drive #(.NALT(NALT)) u_drv (
            .fsel    (ctrl_q[i].fsel),
            .alt_inv (ctrl_q[i].alt_inv),
            .grp_out (ctrl_q[i].grp_out),
            .out_val (ctrl_q[i].out_val),
            .dir_out (ctrl_q[i].dir_out),
            .od      (ctrl_q[i].od),
            .gated   (gated),
            .grp_bit (grp_q[i]),
            .alt     (alt_fn[i*NALT +: NALT]),
            .pad_o   (pad_out[i]),
            .pad_oe  (pad_oe[i])
        );
    end

    gpio_input_path #(.NPINS(NPINS)) u_in (
        .clk    (clk),
        .rst    (rst),
        .pad_in (pad_in),
        .enable (in_en),
        .mode   (mode_flat),
        .clear  (stat_clr),
        .level  (in_lvl),
        .status (int_stat)
    );

    assign irq = |int_stat;

endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker
    import gpio_bank_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 7
) (
    input logic                clk,
    input logic                rst,
    input logic [NPINS*32-1:0] ctrl_flat,
    input logic [NPINS-1:0]    status,
    input logic [NPINS-1:0]    pad_oe,
    input logic [NPINS-1:0]    pad_out,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_wdata,
    input logic                irq
);

    logic stat_wr;
    assign stat_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_INT_STAT));

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        pin_ctrl_t c;
        assign c = pin_ctrl_t'(ctrl_flat[i*32 +: 32]);

        // R4: an open-drain pin never drives a high level
        a_r4_od_never_high: assert property (@(posedge clk) disable iff (rst)
            (c.od && pad_oe[i]) |-> !pad_out[i]);

        // R4: an input-direction pin keeps its driver released
        a_r4_input_released: assert property (@(posedge clk) disable iff (rst)
            !c.dir_out |-> !pad_oe[i]);

        // R6: power gating value 2 releases the driver
        a_r6_gated_no_drive: assert property (@(posedge clk) disable iff (rst)
            (c.pwr_sel == PWR_OFF) |-> !pad_oe[i]);

        // R8: status is sticky until a write of 1 to its bit
        a_r8_status_sticky: assert property (@(posedge clk) disable iff (rst)
            (status[i] && !(stat_wr && bus_wdata[i])) |=> status[i]);

        // R8: a disabled input produces no new status
        a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
            (c.in_off && !status[i]) |=> !status[i]);
    end

    // R9: the interrupt only drops after a write to the status word
    a_r9_irq_drop_by_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> $past(stat_wr));

endmodule

bind gpio_bank_ctrl gpio_bank_checker #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_flat (ctrl_flat),
    .status    (int_stat),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq)
);

// File: tb/sim_gpio_bank_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_bank_ctrl;

    localparam int N = 32;
    localparam int A = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [6:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [31:0]   pad_in = '0;
    logic [31:0]   pad_out, pad_oe, pad_slew;
    logic [63:0]   pad_pull, pad_drive;
    logic [223:0]  alt_fn = '0;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    gpio_bank_ctrl u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull),
        .pad_slew(pad_slew), .pad_drive(pad_drive), .alt_fn(alt_fn), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_ctrl [N];
    logic [31:0] m_cfg  [N];
    logic [31:0] m_grp, m_stat, m_s1, m_s2, m_s3;

    function automatic bit m_en(int i);
        return !m_ctrl[i][15] && (m_ctrl[i][3:2] != 2'd2);
    endfunction

    function automatic logic [31:0] m_lvl();
        logic [31:0] v;
        for (int i = 0; i < N; i++) v[i] = m_s2[i] && m_en(i);
        return v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_ctrl[i] <= 32'h40;
                m_cfg[i]  <= 32'h0;
            end
            m_grp <= 0; m_stat <= 0; m_s1 <= 0; m_s2 <= 0; m_s3 <= 0;
        end else begin
            logic [31:0] ev;
            logic [31:0] clr;
            ev = 0;
            for (int i = 0; i < N; i++) begin
                if (m_en(i)) begin
                    case (int'(m_ctrl[i][7:4]))
                        0:  ev[i] = !m_s2[i];
                        1:  ev[i] = m_s2[i];
                        13: ev[i] = m_s2[i] && !m_s3[i];
                        14: ev[i] = !m_s2[i] && m_s3[i];
                        15: ev[i] = m_s2[i] != m_s3[i];
                        default: ev[i] = 1'b0;
                    endcase
                end
            end
            clr = (bus_wr && bus_addr == 7'd34) ? bus_wdata : 32'h0;
            m_stat <= (m_stat & ~clr) | ev;
            m_s1 <= pad_in; m_s2 <= m_s1; m_s3 <= m_s2;
            if (bus_wr) begin
                if (bus_addr < 7'd32) m_ctrl[bus_addr] <= bus_wdata & 32'h1FFFF;
                if (bus_addr == 7'd33) m_grp <= bus_wdata;
                if (bus_addr >= 7'd64 && bus_addr < 7'd96)
                    m_cfg[bus_addr - 7'd64] <= bus_wdata & 32'h31;
            end
        end
    end

    function automatic logic [1:0] m_pad(int i);
        logic [31:0] c;
        int sel;
        bit src, drv;
        c = m_ctrl[i];
        sel = int'(c[14:12]);
        if (sel == 0) src = c[10] ? m_grp[i] : c[16];
        else          src = alt_fn[i*7 + sel - 1] ^ c[11];
        drv = c[9] && (c[3:2] != 2'd2);
        if (c[8]) return {drv && !src, 1'b0};
        return {drv, drv && src};
    endfunction

    function automatic logic [31:0] m_rd(int a);
        if (a < 32)  return m_ctrl[a] | (32'(m_lvl()[a]) << 24);
        if (a == 32) return m_lvl();
        if (a == 33) return m_grp;
        if (a == 34) return m_stat;
        if (a >= 64 && a < 96) return m_cfg[a-64];
        return 0;
    endfunction

    // ---------------- check helpers ----------------
    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [31:0] eoe, eout, eslew;
        logic [63:0] epull, edrv;
        for (int i = 0; i < N; i++) begin
            logic [1:0] p;
            p = m_pad(i);
            eoe[i] = p[1]; eout[i] = p[0];
            epull[i*2 +: 2] = m_ctrl[i][1:0];
            eslew[i] = m_cfg[i][0];
            edrv[i*2 +: 2] = m_cfg[i][5:4];
        end
        chk("R4 pad_oe", 64'(pad_oe), 64'(eoe));
        chk("R3 pad_out", 64'(pad_out), 64'(eout));
        chk("R9 irq", 64'(irq), 64'(m_stat != 0));
        chk("R2 rdata", 64'(bus_rdata), 64'(m_rd(int'(bus_addr))));
        chk("R10 pads", {pad_pull ^ epull, pad_drive ^ edrv} == '0 ? 64'(pad_slew) : 64'hBAD,
            64'(eslew));
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(int a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = 7'(a); bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic rd(int a, output logic [31:0] v);
        bus_addr = 7'(a);
        #0.1;
        v = bus_rdata;
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] v;
        ticks(3);
        rst = 1'b0;
        tick();

        // R1 reset state
        rd(0, v);  chk("R1 ctrl reset", v, 32'h40);
        rd(33, v); chk("R1 grp reset", v, 0);
        rd(34, v); chk("R1 stat reset", v, 0);
        rd(70, v); chk("R1 cfg reset", v, 0);
        chk("R1 oe reset", pad_oe, 0);
        chk("R1 irq reset", irq, 0);

        // R2 map and masks
        wr(0, 32'hFFFF_FFFF);
        rd(0, v);  chk("R2 ctrl mask", v, 32'h0001_FFFF);
        wr(0, 32'h40);
        wr(32, 32'hFFFF_FFFF);
        rd(32, v); chk("R2 pin-in read-only", v, 0);
        rd(40, v); chk("R2 unmapped", v, 0);

        // R3 output source
        wr(1, 32'h0001_0240);
        chk("R3 own bit", {pad_oe[1], pad_out[1]}, 2'b11);
        wr(1, 32'h0001_0640);
        chk("R3 grouped low", {pad_oe[1], pad_out[1]}, 2'b10);
        wr(33, 32'h2);
        chk("R3 grouped high", {pad_oe[1], pad_out[1]}, 2'b11);
        wr(1, 32'h0000_0640);
        chk("R3 bit16 ignored", {pad_oe[1], pad_out[1]}, 2'b11);

        // R4 direction and buffer type
        wr(2, 32'h0000_0340);
        chk("R4 od low", {pad_oe[2], pad_out[2]}, 2'b10);
        wr(2, 32'h0001_0340);
        chk("R4 od high released", {pad_oe[2], pad_out[2]}, 2'b00);
        wr(2, 32'h0001_0040);
        chk("R4 input dir", {pad_oe[2], pad_out[2]}, 2'b00);

        // R5 alternate functions
        wr(3, 32'h0000_5240);
        alt_fn[3*7 + 4] = 1'b1; tick();
        chk("R5 alt5 high", {pad_oe[3], pad_out[3]}, 2'b11);
        alt_fn[3*7 + 4] = 1'b0; tick();
        chk("R5 alt5 low", {pad_oe[3], pad_out[3]}, 2'b10);
        wr(3, 32'h0000_5A40);
        chk("R5 alt5 inverted", {pad_oe[3], pad_out[3]}, 2'b11);

        // R6 power gating
        wr(4, 32'h0001_0248);
        chk("R6 gated oe", {pad_oe[4], pad_out[4]}, 2'b00);
        pad_in[4] = 1'b1; ticks(3);
        rd(32, v); chk("R6 gated input", v[4], 0);
        wr(4, 32'h0001_024C);
        chk("R6 reserved acts normal", {pad_oe[4], pad_out[4]}, 2'b11);
        rd(32, v); chk("R6 reserved input", v[4], 1);

        // R7 synchroniser latency and input disable
        pad_in[5] = 1'b1; tick();
        rd(32, v); chk("R7 one edge", v[5], 0);
        tick();
        rd(32, v); chk("R7 two edges", v[5], 1);
        rd(5, v);  chk("R7 ctrl bit24", v, 32'h0100_0040);
        wr(5, 32'h0000_8040);
        rd(5, v);  chk("R7 disabled ctrl", v, 32'h0000_8040);
        rd(32, v); chk("R7 disabled level", v[5], 0);

        // R8 edge modes
        wr(6, 32'hD0);
        pad_in[6] = 1'b1; ticks(2);
        rd(34, v); chk("R8 rise not yet", v[6], 0);
        tick();
        rd(34, v); chk("R8 rise set", v[6], 1);
        chk("R9 irq on edge", irq, 1);
        wr(34, ~32'h40);
        rd(34, v); chk("R8 write 0 keeps", v[6], 1);
        wr(34, 32'h40);
        rd(34, v); chk("R8 w1c clears", v[6], 0);
        pad_in[6] = 1'b0; ticks(4);
        rd(34, v); chk("R8 rise ignores fall", v[6], 0);
        wr(6, 32'hE0);
        pad_in[6] = 1'b1; ticks(4);
        rd(34, v); chk("R8 fall ignores rise", v[6], 0);
        pad_in[6] = 1'b0; ticks(3);
        rd(34, v); chk("R8 fall set", v[6], 1);
        wr(34, 32'h40);
        wr(6, 32'h70);
        pad_in[6] = 1'b1; ticks(4); pad_in[6] = 1'b0; ticks(4);
        rd(34, v); chk("R8 unlisted code quiet", v[6], 0);
        wr(6, 32'hF0);
        pad_in[6] = 1'b1; ticks(3);
        rd(34, v); chk("R8 both rise", v[6], 1);
        wr(34, 32'h40);
        pad_in[6] = 1'b0; ticks(3);
        rd(34, v); chk("R8 both fall", v[6], 1);
        wr(34, 32'h40);
        wr(6, 32'h40);

        // R9 level modes
        pad_in[7] = 1'b1; ticks(3);
        wr(7, 32'h10);
        tick();
        rd(34, v); chk("R9 level high set", v[7], 1);
        wr(34, 32'h80);
        rd(34, v); chk("R9 level resists clear", v[7], 1);
        pad_in[7] = 1'b0; ticks(3);
        rd(34, v); chk("R9 sticky after level", v[7], 1);
        wr(7, 32'h40);
        wr(34, 32'h80);
        rd(34, v); chk("R9 cleared", v[7], 0);
        chk("R9 irq low", irq, 0);
        wr(7, 32'h00);
        tick();
        rd(34, v); chk("R9 level low set", v[7], 1);
        wr(7, 32'h40);
        wr(34, 32'h80);
        chk("R9 irq cleared", irq, 0);

        // R10 static pad settings
        wr(8, 32'h42);
        chk("R10 pull", pad_pull[17:16], 2'd2);
        wr(72, 32'hFFFF_FFFF);
        rd(72, v); chk("R10 cfg mask", v, 32'h31);
        chk("R10 slew", pad_slew[8], 1);
        chk("R10 drive", pad_drive[17:16], 2'd3);

        // Mixed traffic compared cycle by cycle against the model
        for (int k = 0; k < 4000; k++) begin
            int a;
            a = int'($urandom_range(0, 67));
            if (a > 34) a = a + 29;
            bus_addr  = 7'(a);
            bus_wr    = ($urandom_range(0, 3) == 0);
            bus_wdata = $urandom;
            if ($urandom_range(0, 2) == 0) pad_in = $urandom;
            if ($urandom_range(0, 3) == 0) alt_fn[$urandom_range(0, 223)] ^= 1'b1;
            tick();
        end
        bus_wr = 1'b0;
        tick();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule